// File: doc/BRIEF.md
# Whole-Array Erase and Blank-Check Sequencer

This controller drives the pins of an electrically erasable EPROM through a complete chip erase. After a start command it raises the programming supply and the high-voltage select on the address line that qualifies erase. It holds the rest of the address bus at zero and drives all ones onto the data bus. It then strobes the program line low for one long timed pulse. After a hold interval it drops the high voltages, switches the supplies to their lowered margin level, waits for them to settle, and reads the array from the first location upward. Each byte is compared against all ones.

The sweep stops at the first byte that is not blank. That byte triggers another erase pulse, until a limit on the number of pulses is reached. A run ends with `done` high, a pass/fail flag and, on failure, the address that was still not blank in the last sweep. Supply generation sits outside the block. It is steered through select outputs, and the analog settling is covered by fixed waits. Every duration is a parameter counted in clock cycles.

Top module: `erase_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done` and `pass` are 0, `ceN`, `oeN` and `pgmN` are 1, and `vppHigh`, `hvSel`, `marginSel` and `dataDrive` are 0.
- R2: `start` is acted on only while idle. A start clears `done` on the following cycle, and a start raised during a run does not change its pulse count, its length or its result.
- R3: Before each erase pulse, the erase qualifiers are applied for exactly SETUP_CYC cycles. These are `vppHigh`=1, `hvSel`=1, `ceN`=0, `oeN`=1, `pgmN`=1, `dataDrive`=1, `dataOut` all ones and `addrOut`=0.
- R4: Each erase pulse holds `pgmN` low for exactly PULSE_CYC consecutive cycles, with all R3 qualifiers unchanged.
- R5: After `pgmN` returns high, the R3 qualifiers, including address zero, stay applied for exactly HOLD_CYC cycles.
- R6: Reads (`oeN`=0) happen only with `vppHigh`=0, `hvSel`=0 and `marginSel`=1. The first read of each sweep follows exactly SETTLE_CYC cycles of margin supplies with `oeN` high.
- R7: A sweep reads one address per cycle, ascending from 0. A byte is blank only when all its bits are 1.
- R8: A non-blank byte ends the sweep in that cycle and starts a new erase pulse sequence (back to R3), unless the pulse limit is reached.
- R9: When a sweep reaches the last address with every byte blank, the run ends with `done`=1, `pass`=1 and `failAddr`=0.
- R10: When a non-blank byte is found after MAX_PULSES pulses, the run ends with `done`=1, `pass`=0 and `failAddr` set to that byte's address. No more than MAX_PULSES pulses are ever issued.
- R11: `busy` is high for exactly the sum, over the attempts, of SETUP_CYC+PULSE_CYC+HOLD_CYC+SETTLE_CYC plus the number of bytes read in that attempt's sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase run (sampled while idle) |
| readData | input | DW | Data read from the memory array |
| addrOut | output | AW | Address bus to the memory |
| dataOut | output | DW | Data bus value driven during erase |
| dataDrive | output | 1 | Enables the data bus driver |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| pgmN | output | 1 | Program/erase strobe, active low |
| vppHigh | output | 1 | Selects high programming supply |
| hvSel | output | 1 | Selects high voltage on the erase-qualifier address line |
| marginSel | output | 1 | Selects lowered margin supplies for verify |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid until next start |
| pass | output | 1 | Array verified blank |
| failAddr | output | AW | First non-blank address of the last sweep on failure |

## Verification
The bench goes after the sweep boundaries. It places a stubborn byte at every address in turn, including address 0 and the last address. A sequencer that stopped one address early or late, or that latched the address of the next read, would report the wrong `failAddr`. It also targets the pulse limit from both sides: arrays that need exactly MAX_PULSES pulses must pass and those needing one more must fail. An off-by-one in the attempt counter flips one of these verdicts and shows up as a wrong pulse count. Pulse width, setup, hold and settle intervals are measured at the pins, and total busy time is compared against an arithmetic sum over attempts. A skipped or doubled wait therefore shows up even when the verdict is right.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_SETTLE,
    ST_VERIFY
  } seqState_t;

  typedef enum logic [1:0] {
    TM_SETUP,
    TM_PULSE,
    TM_HOLD,
    TM_SETTLE
  } timerSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      timerLoad;
    timerSel_t timerSel;
    logic      addrClr;
    logic      addrInc;
    logic      tryClr;
    logic      tryInc;
    logic      resClr;
    logic      resPass;
    logic      resFail;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic timerZero;
    logic addrLast;
    logic addrZero;
    logic blank;
    logic tryLast;
  } dpStat_t;

endpackage

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 100,
  parameter int PULSE_CYC  = 5000000,
  parameter int HOLD_CYC   = 100,
  parameter int SETTLE_CYC = 100,
  parameter int MAX_PULSES = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       ctrl,
  input  logic [DW-1:0] readData,
  output dpStat_t       stat,
  output logic [AW-1:0] addrCnt,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] failAddr
);

  localparam int LONG_A  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int LONG_B  = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int CW      = $clog2(MAX_PULSES + 1);
  localparam logic [AW-1:0] ADDR_LAST = {AW{1'b1}};

  logic [TW-1:0] timer;
  logic [CW-1:0] tryCnt;

  // interval timer: loaded with length-1, counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (ctrl.timerLoad) begin
      case (ctrl.timerSel)
        TM_SETUP:  timer <= TW'(SETUP_CYC - 1);
        TM_PULSE:  timer <= TW'(PULSE_CYC - 1);
        TM_HOLD:   timer <= TW'(HOLD_CYC - 1);
        default:   timer <= TW'(SETTLE_CYC - 1);
      endcase
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  // sweep address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (ctrl.addrClr) begin
      addrCnt <= '0;
    end else if (ctrl.addrInc) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  // pulses issued in this run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tryCnt <= '0;
    end else if (ctrl.tryClr) begin
      tryCnt <= '0;
    end else if (ctrl.tryInc) begin
      tryCnt <= tryCnt + 1'b1;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      pass     <= 1'b0;
      failAddr <= '0;
    end else if (ctrl.resClr) begin
      done     <= 1'b0;
      pass     <= 1'b0;
      failAddr <= '0;
    end else if (ctrl.resPass) begin
      done <= 1'b1;
      pass <= 1'b1;
    end else if (ctrl.resFail) begin
      done     <= 1'b1;
      pass     <= 1'b0;
      failAddr <= addrCnt;
    end
  end

  always_comb begin
    stat.timerZero = (timer == '0);
    stat.addrLast  = (addrCnt == ADDR_LAST);
    stat.addrZero  = (addrCnt == '0);
    stat.blank     = &readData;
    stat.tryLast   = (tryCnt == CW'(MAX_PULSES));
  end

  assert_try_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt <= CW'(MAX_PULSES));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.addrInc && !ctrl.addrClr) |=> addrCnt == $past(addrCnt) + 1'b1);

  assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    ceN,
  output logic    oeN,
  output logic    pgmN,
  output logic    vppHigh,
  output logic    hvSel,
  output logic    marginSel,
  output logic    dataDrive,
  output logic    busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          nextState      = ST_SETUP;
          ctrl.timerLoad = 1'b1;
          ctrl.timerSel  = TM_SETUP;
          ctrl.tryClr    = 1'b1;
          ctrl.resClr    = 1'b1;
          ctrl.addrClr   = 1'b1;
        end
      end
      ST_SETUP: begin
        if (stat.timerZero) begin
          nextState      = ST_PULSE;
          ctrl.timerLoad = 1'b1;
          ctrl.timerSel  = TM_PULSE;
        end
      end
      ST_PULSE: begin
        if (stat.timerZero) begin
          nextState      = ST_HOLD;
          ctrl.timerLoad = 1'b1;
          ctrl.timerSel  = TM_HOLD;
          ctrl.tryInc    = 1'b1;
        end
      end
      ST_HOLD: begin
        if (stat.timerZero) begin
          nextState      = ST_SETTLE;
          ctrl.timerLoad = 1'b1;
          ctrl.timerSel  = TM_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (stat.timerZero) begin
          nextState    = ST_VERIFY;
          ctrl.addrClr = 1'b1;
        end
      end
      ST_VERIFY: begin
        if (!stat.blank) begin
          if (stat.tryLast) begin
            nextState    = ST_IDLE;
            ctrl.resFail = 1'b1;
          end else begin
            nextState      = ST_SETUP;
            ctrl.timerLoad = 1'b1;
            ctrl.timerSel  = TM_SETUP;
            ctrl.addrClr   = 1'b1;
          end
        end else if (stat.addrLast) begin
          nextState    = ST_IDLE;
          ctrl.resPass = 1'b1;
        end else begin
          ctrl.addrInc = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  logic qualify;
  assign qualify   = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
  assign vppHigh   = qualify;
  assign hvSel     = qualify;
  assign dataDrive = qualify;
  assign ceN       = (state == ST_IDLE);
  assign oeN       = (state != ST_VERIFY);
  assign pgmN      = (state != ST_PULSE);
  assign marginSel = (state == ST_SETTLE) || (state == ST_VERIFY);
  assign busy      = (state != ST_IDLE);

  assert_pulse_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !pgmN |-> stat.addrZero);

  assert_read_after_margin_R6: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> $past(marginSel) && !$past(hvSel));

  assert_fail_only_at_limit_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.resFail |-> stat.tryLast && !stat.blank);

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 100,
  parameter int PULSE_CYC  = 5000000,
  parameter int HOLD_CYC   = 100,
  parameter int SETTLE_CYC = 100,
  parameter int MAX_PULSES = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [DW-1:0] readData,
  output logic [AW-1:0] addrOut,
  output logic [DW-1:0] dataOut,
  output logic          dataDrive,
  output logic          ceN,
  output logic          oeN,
  output logic          pgmN,
  output logic          vppHigh,
  output logic          hvSel,
  output logic          marginSel,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] failAddr
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  erase_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stat      (stat),
    .ctrl      (ctrl),
    .ceN       (ceN),
    .oeN       (oeN),
    .pgmN      (pgmN),
    .vppHigh   (vppHigh),
    .hvSel     (hvSel),
    .marginSel (marginSel),
    .dataDrive (dataDrive),
    .busy      (busy)
  );

  erase_seq_dp #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC), .MAX_PULSES(MAX_PULSES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .readData (readData),
    .stat     (stat),
    .addrCnt  (addrOut),
    .done     (done),
    .pass     (pass),
    .failAddr (failAddr)
  );

  assign dataOut = dataDrive ? {DW{1'b1}} : {DW{1'b0}};

endmodule

// File: tb/sim_erase_seq.sv
module sim_erase_seq;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NB = 1 << AW;
  localparam int SC = 3;
  localparam int PC = 8;
  localparam int HC = 2;
  localparam int TC = 4;
  localparam int MP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] readData;
  logic [AW-1:0] addrOut, failAddr;
  logic [DW-1:0] dataOut;
  logic dataDrive, ceN, oeN, pgmN, vppHigh, hvSel, marginSel, busy, done, pass;

  always #10 clk = ~clk;

  erase_seq #(
    .AW(AW), .DW(DW), .SETUP_CYC(SC), .PULSE_CYC(PC), .HOLD_CYC(HC),
    .SETTLE_CYC(TC), .MAX_PULSES(MP)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .readData(readData),
    .addrOut(addrOut), .dataOut(dataOut), .dataDrive(dataDrive),
    .ceN(ceN), .oeN(oeN), .pgmN(pgmN), .vppHigh(vppHigh), .hvSel(hvSel),
    .marginSel(marginSel), .busy(busy), .done(done), .pass(pass),
    .failAddr(failAddr)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // array model: a byte reads blank once it has seen need[a] pulses
  int need [NB];
  int pulses = 0;
  int busyCnt = 0;

  always_comb begin
    if (pulses >= need[addrOut]) readData = {DW{1'b1}};
    else                         readData = {{(DW-AW){1'b0}}, addrOut};
  end

  // pin monitor
  bit prevPgm = 1'b1, prevOe = 1'b1, inHold = 1'b0;
  int setupRun = 0, lowRun = 0, holdRun = 0, settleRun = 0, readIdx = 0;

  always @(negedge clk) begin
    if (rstN) begin
      automatic bit pat = vppHigh && hvSel && !ceN && oeN && pgmN && dataDrive
                          && (addrOut == '0) && (dataOut == {DW{1'b1}});
      if (!pgmN && prevPgm)
        check(setupRun == SC, "R3 setup cycles", setupRun, SC);
      if (!pgmN)
        check(vppHigh && hvSel && !ceN && oeN && addrOut == '0 && dataDrive,
              "R4 qualifiers during pulse", int'(addrOut), 0);
      if (pgmN && !prevPgm) begin
        check(lowRun == PC, "R4 pulse width", lowRun, PC);
        pulses++;
        inHold = 1'b1;
        holdRun = 0;
      end
      if (inHold) begin
        if (pat) holdRun++;
        else begin
          check(holdRun == HC, "R5 hold cycles", holdRun, HC);
          inHold = 1'b0;
        end
      end
      if (!oeN) begin
        if (prevOe) begin
          check(settleRun == TC, "R6 settle cycles", settleRun, TC);
          readIdx = 0;
        end
        check(!hvSel && !vppHigh && marginSel, "R6 read with margin supplies",
              int'(hvSel), 0);
        check(int'(addrOut) == readIdx, "R7 ascending address", int'(addrOut), readIdx);
        readIdx++;
      end
      if (busy && !vppHigh && !hvSel && marginSel && oeN) settleRun++;
      else settleRun = 0;
      setupRun = pat ? setupRun + 1 : 0;
      lowRun   = !pgmN ? lowRun + 1 : 0;
      prevPgm  = pgmN;
      prevOe   = oeN;
      if (busy) busyCnt++;
    end
  end

  function automatic int firstBad(input int k);
    for (int a = 0; a < NB; a++) if (need[a] > k) return a;
    return -1;
  endfunction

  task automatic runCase(input string name, input bit midStart);
    int expP = 0, expBusy = 0, fb = -1, cyc = 0;
    bit expPass;
    for (int k = 1; k <= MP; k++) begin
      expP = k;
      fb = firstBad(k);
      expBusy += SC + PC + HC + TC + ((fb < 0) ? NB : fb + 1);
      if (fb < 0) break;
    end
    expPass = (fb < 0);
    pulses = 0;
    busyCnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && busy, "R2 start clears done", int'(done), 0);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 5) start = 1'b1;
      if (midStart && cyc == 6) start = 1'b0;
    end
    check(done, "R2 run completes", int'(done), 1);
    check(pulses == expP, expPass ? "R8 pulse count" : "R10 pulse limit", pulses, expP);
    check(busyCnt == expBusy, "R11 busy length", busyCnt, expBusy);
    if (expPass) begin
      check(pass == 1'b1, "R9 pass flag", int'(pass), 1);
      check(failAddr == '0, "R9 failAddr zero", int'(failAddr), 0);
    end else begin
      check(pass == 1'b0, "R10 fail flag", int'(pass), 0);
      check(int'(failAddr) == fb, "R10 failAddr", int'(failAddr), fb);
    end
    check(!busy && ceN && pgmN && oeN && !vppHigh && !hvSel, "R1 idle after run",
          int'(busy), 0);
    $display("case %s done: pulses %0d", name, pulses);
  endtask

  initial begin
    for (int a = 0; a < NB; a++) need[a] = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass && ceN && oeN && pgmN, "R1 reset pins", int'(busy), 0);
    check(!vppHigh && !hvSel && !marginSel && !dataDrive, "R1 reset selects",
          int'(vppHigh), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done, "R1 idle after release", int'(busy), 0);

    runCase("already blank", 1'b0);

    for (int a = 0; a < NB; a++) need[a] = a % 4;
    runCase("needs three", 1'b0);
    runCase("needs three, start while busy", 1'b1);

    for (int a = 0; a < NB; a++) need[a] = 0;
    need[NB-1] = MP;
    runCase("limit exactly, last byte", 1'b0);

    need[NB-1] = 0;
    need[0] = 2;
    runCase("first byte stubborn", 1'b0);

    for (int b = 0; b < NB; b++) begin
      for (int a = 0; a < NB; a++) need[a] = 1;
      need[b] = MP + 1;
      runCase("one dead byte", 1'b0);
    end

    for (int a = 0; a < NB; a++) need[a] = 0;
    need[12] = MP + 1;
    need[9]  = MP + 2;
    need[3]  = MP;
    runCase("two dead bytes", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule